// File: doc/BRIEF.md
# Cache-Coordinate Trap Return Address Register

This block keeps the return address of a trap in compact form: rather than a full virtual address, it records where the faulting instruction sits in the instruction cache. That position is the set index, the way, and the byte offset within the line. Software never sees that form.

When software reads the register, the block looks up the tag array at the recorded set and way. It then rebuilds the virtual address by placing the stored set index and offset below the returned tag. The lookup is internal and changes nothing that software can observe.

While the register holds a cache position, the block drives a no-evict request for that set and way, so the referenced line stays resident. A software write of a full address switches the register to plain-address mode. In that mode the no-evict request is released and reads return the written value without a lookup.

Top module: `trap_pc_coord`

## Requirements
- R1: After reset the register is in plain-address mode holding 0. `pin_valid` and `rd_valid` are low, and a read returns 0 without raising `tag_rd_en`.
- R2: From the cycle after a `trap_valid` cycle, `pin_valid` is high and `pin_set`/`pin_way` equal the captured set and way. This holds until the next capture or write.
- R3: In cache-position mode, a read request raises `tag_rd_en` in the same cycle, with `tag_rd_set`/`tag_rd_way` equal to the stored set and way. `tag_rd_en` is never high without `rd_req`.
- R4: `rd_valid` is high for exactly the one cycle after each `rd_req` cycle, and low otherwise.
- R5: A read in cache-position mode returns `{tag, set, offset}`. The tag (upper `VA_W-SET_W-OFF_W` bits) comes from `tag_rd_tag` in the `rd_valid` cycle. The set index and the byte offset (lowest `OFF_W` bits) are the stored ones.
- R6: A `wr_valid` cycle without a trap selects plain-address mode. `pin_valid` is low from the next cycle, and later reads return `wr_addr` with `tag_rd_en` held low.
- R7: A trap in the same cycle as a read request takes priority: the read returns the newly captured position, resolved. A trap in the same cycle as a write also wins over the write.
- R8: A write in the same cycle as a read request (with no trap) makes the read return the written address.
- R9: Reads change no state: repeated reads return the same address, and `pin_valid`/`pin_set`/`pin_way` are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Capture a new cache position this cycle |
| trap_set | input | SET_W | Set index of the line holding the last executed instruction |
| trap_way | input | WAY_W | Way of that line |
| trap_off | input | OFF_W | Byte offset of the instruction within the line |
| wr_valid | input | 1 | Software write of a full virtual address |
| wr_addr | input | VA_W | Address written by software |
| rd_req | input | 1 | Software read request |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | VA_W | Resolved virtual address |
| tag_rd_en | output | 1 | Tag array read strobe |
| tag_rd_set | output | SET_W | Tag array read set |
| tag_rd_way | output | WAY_W | Tag array read way |
| tag_rd_tag | input | VA_W-SET_W-OFF_W | Tag returned one cycle after the strobe |
| pin_valid | output | 1 | No-evict request for the referenced line |
| pin_set | output | SET_W | Set of the pinned line |
| pin_way | output | WAY_W | Way of the pinned line |

## Verification
The bench aims at same-cycle collisions first. A read together with a trap must return the fresh capture; a design that read the old state would return the previous address and also send the wrong set to the tag array. A read together with a write must return the written value, and a trap together with a write must leave the block in cache-position mode with the line pinned. A design that left the pin raised after a write would hold a line that nothing references any more. A design that looked up the tag array in plain mode, or sampled the tag one cycle off, would return a corrupted upper field. Back-to-back reads and random mixes check that reads never disturb the stored state.

// File: rtl/trap_pc_pkg.sv
package trap_pc_pkg;

    localparam int DEF_VA_W  = 32;
    localparam int DEF_SET_W = 6;
    localparam int DEF_WAY_W = 2;
    localparam int DEF_OFF_W = 6;

    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_COORD = 1'b1
    } tpc_mode_e;

endpackage

// File: rtl/tpc_state.sv
module tpc_state
    import trap_pc_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int SET_W = DEF_SET_W,
    parameter int WAY_W = DEF_WAY_W,
    parameter int OFF_W = DEF_OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_valid,
    input  logic [SET_W-1:0] trap_set,
    input  logic [WAY_W-1:0] trap_way,
    input  logic [OFF_W-1:0] trap_off,
    input  logic             wr_valid,
    input  logic [VA_W-1:0]  wr_addr,
    output tpc_mode_e        nxt_mode,
    output logic [VA_W-1:0]  nxt_store,
    output tpc_mode_e        cur_mode,
    output logic [VA_W-1:0]  cur_store
);
    localparam int COORD_W = WAY_W + SET_W + OFF_W;

    tpc_mode_e       mode_q;
    logic [VA_W-1:0] store_q;

    // Cache position shares the address storage: {way, set, off} in the low bits.
    always_comb begin
        nxt_mode  = mode_q;
        nxt_store = store_q;
        if (trap_valid) begin
            nxt_mode  = MODE_COORD;
            nxt_store = '0;
            nxt_store[COORD_W-1:0] = {trap_way, trap_set, trap_off};
        end else if (wr_valid) begin
            nxt_mode  = MODE_PLAIN;
            nxt_store = wr_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_PLAIN;
            store_q <= '0;
        end else begin
            mode_q  <= nxt_mode;
            store_q <= nxt_store;
        end
    end

    assign cur_mode  = mode_q;
    assign cur_store = store_q;
endmodule

// File: rtl/tpc_resolve.sv
module tpc_resolve
    import trap_pc_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int SET_W = DEF_SET_W,
    parameter int WAY_W = DEF_WAY_W,
    parameter int OFF_W = DEF_OFF_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_req,
    input  tpc_mode_e                   nxt_mode,
    input  logic [VA_W-1:0]             nxt_store,
    output logic                        tag_rd_en,
    output logic [SET_W-1:0]            tag_rd_set,
    output logic [WAY_W-1:0]            tag_rd_way,
    input  logic [VA_W-SET_W-OFF_W-1:0] tag_rd_tag,
    output logic                        rd_valid,
    output logic [VA_W-1:0]             rd_data
);
    localparam int SET_LO = OFF_W;
    localparam int WAY_LO = OFF_W + SET_W;

    logic            pend_q;
    tpc_mode_e       pmode_q;
    logic [VA_W-1:0] pstore_q;

    assign tag_rd_en  = rd_req && (nxt_mode == MODE_COORD);
    assign tag_rd_set = nxt_store[SET_LO +: SET_W];
    assign tag_rd_way = nxt_store[WAY_LO +: WAY_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            pmode_q  <= MODE_PLAIN;
            pstore_q <= '0;
        end else begin
            pend_q <= rd_req;
            if (rd_req) begin
                pmode_q  <= nxt_mode;
                pstore_q <= nxt_store;
            end
        end
    end

    assign rd_valid = pend_q;

    always_comb begin
        rd_data = '0;
        if (pend_q) begin
            if (pmode_q == MODE_COORD)
                rd_data = {tag_rd_tag, pstore_q[SET_LO +: SET_W], pstore_q[OFF_W-1:0]};
            else
                rd_data = pstore_q;
        end
    end
endmodule

// File: rtl/trap_pc_coord.sv
module trap_pc_coord
    import trap_pc_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int SET_W = DEF_SET_W,
    parameter int WAY_W = DEF_WAY_W,
    parameter int OFF_W = DEF_OFF_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        trap_valid,
    input  logic [SET_W-1:0]            trap_set,
    input  logic [WAY_W-1:0]            trap_way,
    input  logic [OFF_W-1:0]            trap_off,
    input  logic                        wr_valid,
    input  logic [VA_W-1:0]             wr_addr,
    input  logic                        rd_req,
    output logic                        rd_valid,
    output logic [VA_W-1:0]             rd_data,
    output logic                        tag_rd_en,
    output logic [SET_W-1:0]            tag_rd_set,
    output logic [WAY_W-1:0]            tag_rd_way,
    input  logic [VA_W-SET_W-OFF_W-1:0] tag_rd_tag,
    output logic                        pin_valid,
    output logic [SET_W-1:0]            pin_set,
    output logic [WAY_W-1:0]            pin_way
);
    tpc_mode_e       nxt_mode, cur_mode;
    logic [VA_W-1:0] nxt_store, cur_store;

    tpc_state #(.VA_W(VA_W), .SET_W(SET_W), .WAY_W(WAY_W), .OFF_W(OFF_W)) u_state (
        .clk(clk), .rst(rst),
        .trap_valid(trap_valid), .trap_set(trap_set), .trap_way(trap_way), .trap_off(trap_off),
        .wr_valid(wr_valid), .wr_addr(wr_addr),
        .nxt_mode(nxt_mode), .nxt_store(nxt_store),
        .cur_mode(cur_mode), .cur_store(cur_store)
    );

    tpc_resolve #(.VA_W(VA_W), .SET_W(SET_W), .WAY_W(WAY_W), .OFF_W(OFF_W)) u_resolve (
        .clk(clk), .rst(rst), .rd_req(rd_req),
        .nxt_mode(nxt_mode), .nxt_store(nxt_store),
        .tag_rd_en(tag_rd_en), .tag_rd_set(tag_rd_set), .tag_rd_way(tag_rd_way),
        .tag_rd_tag(tag_rd_tag),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign pin_valid = (cur_mode == MODE_COORD);
    assign pin_set   = cur_store[OFF_W +: SET_W];
    assign pin_way   = cur_store[OFF_W+SET_W +: WAY_W];
endmodule

// File: rtl/trap_pc_coord_chk.sv
module trap_pc_coord_chk #(
    parameter int VA_W  = 32,
    parameter int SET_W = 6,
    parameter int WAY_W = 2,
    parameter int OFF_W = 6
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        trap_valid,
    input logic [SET_W-1:0]            trap_set,
    input logic [WAY_W-1:0]            trap_way,
    input logic                        wr_valid,
    input logic                        rd_req,
    input logic                        rd_valid,
    input logic [VA_W-1:0]             rd_data,
    input logic                        tag_rd_en,
    input logic [VA_W-SET_W-OFF_W-1:0] tag_rd_tag,
    input logic                        pin_valid,
    input logic [SET_W-1:0]            pin_set,
    input logic [WAY_W-1:0]            pin_way
);
    localparam int TAG_W = VA_W - SET_W - OFF_W;

    // R2
    trap_pins_line_chk: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> pin_valid && pin_set == $past(trap_set) && pin_way == $past(trap_way));

    // R3
    lookup_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        tag_rd_en |-> rd_req);

    // R4
    read_answers_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    // R4
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    // R5
    tag_in_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(tag_rd_en)) |-> rd_data[VA_W-1 -: TAG_W] == tag_rd_tag);

    // R6
    write_unpins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !trap_valid) |=> !pin_valid);

    // R9
    read_keeps_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (!trap_valid && !wr_valid) |=> pin_valid == $past(pin_valid)
            && pin_set == $past(pin_set) && pin_way == $past(pin_way));
endmodule

bind trap_pc_coord trap_pc_coord_chk #(.VA_W(VA_W), .SET_W(SET_W), .WAY_W(WAY_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_set(trap_set), .trap_way(trap_way),
    .wr_valid(wr_valid), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .tag_rd_en(tag_rd_en), .tag_rd_tag(tag_rd_tag),
    .pin_valid(pin_valid), .pin_set(pin_set), .pin_way(pin_way)
);

// File: tb/trap_pc_coord_bench.sv
module trap_pc_coord_bench;
    localparam int VA_W  = 32;
    localparam int SET_W = 6;
    localparam int WAY_W = 2;
    localparam int OFF_W = 6;
    localparam int TAG_W = VA_W - SET_W - OFF_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trap_valid = 1'b0;
    logic [SET_W-1:0] trap_set = '0;
    logic [WAY_W-1:0] trap_way = '0;
    logic [OFF_W-1:0] trap_off = '0;
    logic             wr_valid = 1'b0;
    logic [VA_W-1:0]  wr_addr = '0;
    logic             rd_req = 1'b0;
    logic             rd_valid;
    logic [VA_W-1:0]  rd_data;
    logic             tag_rd_en;
    logic [SET_W-1:0] tag_rd_set;
    logic [WAY_W-1:0] tag_rd_way;
    logic [TAG_W-1:0] tag_rd_tag = '0;
    logic             pin_valid;
    logic [SET_W-1:0] pin_set;
    logic [WAY_W-1:0] pin_way;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // expected state
    logic             m_coord = 1'b0;
    logic [SET_W-1:0] m_set = '0;
    logic [WAY_W-1:0] m_way = '0;
    logic [OFF_W-1:0] m_off = '0;
    logic [VA_W-1:0]  m_addr = '0;

    always #4 clk = ~clk;

    trap_pc_coord u_trap_pc_coord (
        .clk(clk), .rst(rst),
        .trap_valid(trap_valid), .trap_set(trap_set), .trap_way(trap_way), .trap_off(trap_off),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .tag_rd_en(tag_rd_en), .tag_rd_set(tag_rd_set), .tag_rd_way(tag_rd_way),
        .tag_rd_tag(tag_rd_tag),
        .pin_valid(pin_valid), .pin_set(pin_set), .pin_way(pin_way)
    );

    function automatic logic [TAG_W-1:0] tag_fn(logic [SET_W-1:0] s, logic [WAY_W-1:0] w);
        logic [31:0] h;
        h = ({24'd0, w, s} + 32'd7) * 32'h9E3779B1;
        return h[31 -: TAG_W];
    endfunction

    function automatic logic [VA_W-1:0] exp_addr();
        if (m_coord) return {tag_fn(m_set, m_way), m_set, m_off};
        return m_addr;
    endfunction

    // tag array model: one-cycle synchronous read
    always @(posedge clk) if (tag_rd_en) tag_rd_tag <= tag_fn(tag_rd_set, tag_rd_way);

    task automatic check(string req, string what, logic [VA_W-1:0] act, logic [VA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check lookup, then outputs after the edge
    task automatic step(logic t, logic [SET_W-1:0] s, logic [WAY_W-1:0] w, logic [OFF_W-1:0] o,
                        logic wr, logic [VA_W-1:0] a, logic rd, string lbl);
        logic [VA_W-1:0] exp;
        trap_valid = t; trap_set = s; trap_way = w; trap_off = o;
        wr_valid = wr; wr_addr = a; rd_req = rd;
        if (t) begin
            m_coord = 1'b1; m_set = s; m_way = w; m_off = o;
        end else if (wr) begin
            m_coord = 1'b0; m_addr = a;
        end
        exp = exp_addr();
        #1;
        check("R3", "tag_rd_en", {31'd0, tag_rd_en}, {31'd0, rd && m_coord});
        if (rd && m_coord) begin
            check("R3", "tag_rd_set", {26'd0, tag_rd_set}, {26'd0, m_set});
            check("R3", "tag_rd_way", {30'd0, tag_rd_way}, {30'd0, m_way});
        end
        @(posedge clk);
        @(negedge clk);
        trap_valid = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
        check("R4", "rd_valid", {31'd0, rd_valid}, {31'd0, rd});
        if (rd) check(lbl, "rd_data", rd_data, exp);
        check("R2", "pin_valid", {31'd0, pin_valid}, {31'd0, m_coord});
        if (m_coord) begin
            check("R2", "pin_set", {26'd0, pin_set}, {26'd0, m_set});
            check("R2", "pin_way", {30'd0, pin_way}, {30'd0, m_way});
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "pin_valid after reset", {31'd0, pin_valid}, 32'd0);
        check("R1", "rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        step(0, 0, 0, 0, 0, 0, 1, "R1");
        // basic capture and resolve
        step(1, 6'd17, 2'd2, 6'd12, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 0, 0, 1, "R9");
        // write releases pin, bypasses lookup
        step(0, 0, 0, 0, 1, 32'hCAFE_0123, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 1, "R6");
        // trap with read in the same cycle
        step(1, 6'd63, 2'd3, 6'd63, 0, 0, 1, "R7");
        // trap with write in the same cycle: trap wins
        step(1, 6'd0, 2'd1, 6'd4, 1, 32'h1111_2222, 1, "R7");
        // write with read in the same cycle
        step(0, 0, 0, 0, 1, 32'hDEAD_BEEF, 1, "R8");
        step(1, 6'd5, 2'd0, 6'd0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 1, 32'h0000_0040, 1, "R8");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic t, wr, rd;
            t  = ($urandom % 6) == 0;
            wr = ($urandom % 7) == 0;
            rd = ($urandom % 2) == 0;
            step(t, 6'($urandom), 2'($urandom), 6'($urandom), wr, $urandom, rd, "R5");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule